// File: doc/BRIEF.md
# Slotted Instruction Word Sequencer with Overlapped Prefetch

This block feeds a decoder from program words that each pack four 5-bit opcodes. It keeps the word being executed in a 20-bit instruction register and presents one slot at a time, starting with the most significant slot. Each slot's opcode is shown on `op_code`, and `op_valid` pulses once in the cycle that slot executes. While the current word runs, the block uses a request/acknowledge memory port to fetch the next word into a one-word buffer. If that fetch is already done when the last slot issues, the next word starts in the following cycle with no gap.

An opcode whose top bit is set needs the memory port or changes the flow of control. While such a slot is current, the block stops asking for instruction words. A prefetched word that was already buffered is thrown away and will be fetched again. The slot then either performs its own access (a data transfer, or a literal read of the word after the current one) or takes a jump target supplied from outside. When it completes, instruction prefetch resumes from the correct address. A word's first slot never issues before that word's read has been acknowledged.

Top module: `slot_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `op_valid` is low. The port requests an instruction word (`mem_kind` 0) at address 0.
- R2: Slots issue in the order bits [19:15], [14:10], [9:5], [4:0]. `op_slot` reads 0, 1, 2, 3 in that order.
- R3: An opcode with bit 4 clear issues in a single cycle, so such slots issue in consecutive cycles.
- R4: When the next word has already been fetched, slot 0 of that word issues in the cycle right after slot 3 of the current word.
- R5: Slot 0 of a word issues no earlier than the cycle after that word's instruction read is acknowledged. While no word is loaded, `op_valid` stays low.
- R6: Instruction-word addresses increase by one for each completed instruction fetch.
- R7: A data opcode (10001 to 10111) requests `mem_kind` 2 at `data_addr`. It issues in the cycle its acknowledge arrives.
- R8: The literal opcode 10000 requests `mem_kind` 1 at the address of the word following the current one, and issues on its acknowledge. The data returned is not executed. The next instruction fetch uses the address after it.
- R9: A transfer opcode (11xxx) issues in one cycle. With `xfer_take` high, the rest of the word is dropped and the next fetch uses `xfer_target`. With `xfer_take` low, execution continues with the next slot.
- R10: While a slot with bit 4 set is current, no instruction fetch is requested. After it completes, prefetch restarts at the word following the current one.
- R11: With a word buffered and a current slot whose bit 4 is clear, `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request, held until acknowledged or withdrawn |
| mem_kind | output | 2 | 0 instruction word, 1 literal read, 2 data access |
| mem_addr | output | 16 | Word address of the request |
| mem_ack | input | 1 | Completes the request presented in the same cycle |
| mem_rdata | input | 20 | Read data, valid with `mem_ack` |
| data_addr | input | 16 | Address used by data opcodes |
| xfer_take | input | 1 | The current transfer opcode changes the flow |
| xfer_target | input | 16 | Word address for a taken transfer |
| op_valid | output | 1 | Current slot executes this cycle |
| op_code | output | 5 | Opcode of the current slot |
| op_slot | output | 2 | Index of the current slot |

## Verification
Several internal faults show up as a shift in `op_valid` timing relative to `mem_ack`. A lost or stale buffer flag shows as either a one-cycle bubble between words or a first slot that issues before its acknowledge, visible within one word time. A wrong program counter or a failed rewind shows in the next `mem_addr` after a literal, data or transfer opcode. An unreset prefetch path shows as an opcode stream that is duplicated or skips a word, within the next four slots.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  typedef enum logic [1:0] {
    KIND_INSN = 2'd0,
    KIND_LIT  = 2'd1,
    KIND_DATA = 2'd2
  } mem_kind_e;
endpackage

// File: rtl/slot_seq_port.sv
// Memory port arbitration: the current slot's own access wins; otherwise
// an instruction prefetch is requested whenever the buffer is empty.
module slot_seq_port
  import slot_seq_pkg::*;
#(
  parameter int SW = 5,
  parameter int AW = 16
) (
  input  logic          ir_valid,
  input  logic [SW-1:0] cur_op,
  input  logic          pf_full,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] data_addr,
  output logic          mem_req,
  output logic [1:0]    mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic          pf_req,
  output logic [AW-1:0] base_pc
);
  // Address of the word after the current one, undoing a finished prefetch.
  function automatic logic [AW-1:0] rewind(input logic [AW-1:0] p, input logic full);
    return p - AW'(full);
  endfunction

  logic cur_ctl, own_mem, is_lit;

  assign cur_ctl = ir_valid & cur_op[SW-1];
  assign own_mem = cur_ctl & ~cur_op[SW-2];
  assign is_lit  = (cur_op[SW-2:0] == '0);
  assign pf_req  = ~pf_full & ~cur_ctl;
  assign base_pc = rewind(pc, pf_full);

  always_comb begin
    mem_req  = own_mem | pf_req;
    mem_kind = KIND_INSN;
    mem_addr = pc;
    if (own_mem) begin
      mem_kind = is_lit ? KIND_LIT : KIND_DATA;
      mem_addr = is_lit ? base_pc : data_addr;
    end
  end
endmodule

// File: rtl/slot_seq_core.sv
// Instruction register, slot pointer, one-word prefetch buffer and PC.
module slot_seq_core #(
  parameter int SW = 5,
  parameter int NS = 4,
  parameter int AW = 16,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1,
  localparam int WW = SW * NS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  input  logic          pf_req,
  input  logic [AW-1:0] base_pc,
  input  logic          xfer_take,
  input  logic [AW-1:0] xfer_target,
  output logic [SW-1:0] cur_op,
  output logic [IW-1:0] slot,
  output logic          ir_valid,
  output logic          pf_full,
  output logic [AW-1:0] pc,
  output logic          issue,
  output logic          pf_done
);
  logic [WW-1:0] ir, pf_buf;

  function automatic logic [SW-1:0] slot_field(input logic [WW-1:0] w, input logic [IW-1:0] i);
    return w[(WW-1) - (int'(i) * SW) -: SW];
  endfunction

  function automatic logic [AW-1:0] ctl_pc(input logic take, input logic lit,
                                           input logic [AW-1:0] tgt, input logic [AW-1:0] base);
    return take ? tgt : base + AW'(lit);
  endfunction

  logic cur_ctl, is_xfer, is_lit, last, taken, word_done, load_buf, ir_free;

  assign cur_op    = slot_field(ir, slot);
  assign cur_ctl   = ir_valid & cur_op[SW-1];
  assign is_xfer   = cur_ctl & cur_op[SW-2];
  assign is_lit    = cur_ctl & (cur_op[SW-2:0] == '0);
  assign issue     = ir_valid & (~cur_op[SW-1] | cur_op[SW-2] | mem_ack);
  assign last      = (slot == IW'(NS - 1));
  assign taken     = issue & is_xfer & xfer_take;
  assign word_done = issue & (last | taken);
  assign pf_done   = pf_req & mem_ack;
  assign load_buf  = word_done & ~taken & pf_full & ~cur_ctl;
  assign ir_free   = ~ir_valid | word_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir       <= '0;
      slot     <= '0;
      ir_valid <= 1'b0;
    end else if (load_buf) begin
      ir   <= pf_buf;
      slot <= '0;
    end else if (pf_done && ir_free) begin
      ir       <= mem_rdata;
      slot     <= '0;
      ir_valid <= 1'b1;
    end else if (word_done) begin
      ir_valid <= 1'b0;
    end else if (issue) begin
      slot <= slot + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_buf  <= '0;
      pf_full <= 1'b0;
    end else if (pf_done && !ir_free) begin
      pf_buf  <= mem_rdata;
      pf_full <= 1'b1;
    end else if (load_buf || (issue && cur_ctl)) begin
      pf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (issue && cur_ctl) pc <= ctl_pc(taken, is_lit, xfer_target, base_pc);
    else if (pf_done) pc <= pc + AW'(1);
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int SW = 5,
  parameter int NS = 4,
  parameter int AW = 16,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1,
  localparam int WW = SW * NS
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [1:0]    mem_kind,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [WW-1:0] mem_rdata,
  input  logic [AW-1:0] data_addr,
  input  logic          xfer_take,
  input  logic [AW-1:0] xfer_target,
  output logic          op_valid,
  output logic [SW-1:0] op_code,
  output logic [IW-1:0] op_slot
);
  // Named internal events and state, visible to the bound checker.
  logic          ev_issue, ev_pf_done, ev_pf_req;
  logic          st_ir_valid, st_pf_full;
  logic [AW-1:0] st_pc, base_pc;
  logic [SW-1:0] cur_op;
  logic [IW-1:0] cur_slot;

  slot_seq_port #(.SW(SW), .AW(AW)) u_port (
    .ir_valid (st_ir_valid),
    .cur_op   (cur_op),
    .pf_full  (st_pf_full),
    .pc       (st_pc),
    .data_addr(data_addr),
    .mem_req  (mem_req),
    .mem_kind (mem_kind),
    .mem_addr (mem_addr),
    .pf_req   (ev_pf_req),
    .base_pc  (base_pc)
  );

  slot_seq_core #(.SW(SW), .NS(NS), .AW(AW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .pf_req     (ev_pf_req),
    .base_pc    (base_pc),
    .xfer_take  (xfer_take),
    .xfer_target(xfer_target),
    .cur_op     (cur_op),
    .slot       (cur_slot),
    .ir_valid   (st_ir_valid),
    .pf_full    (st_pf_full),
    .pc         (st_pc),
    .issue      (ev_issue),
    .pf_done    (ev_pf_done)
  );

  assign op_valid = ev_issue;
  assign op_code  = cur_op;
  assign op_slot  = cur_slot;
endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int SW = 5,
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [SW-1:0] op_code,
  input logic [IW-1:0] op_slot,
  input logic          mem_req,
  input logic [1:0]    mem_kind,
  input logic          mem_ack,
  input logic          xfer_take,
  input logic          st_ir_valid,
  input logic          st_pf_full,
  input logic [AW-1:0] st_pc,
  input logic          ev_pf_done
);
  p_hold_until_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ir_valid |-> !op_valid);

  p_mem_issue_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[SW-1] && !op_code[SW-2]) |-> (mem_req && mem_ack && mem_kind != 2'd0));

  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pf_done |=> (st_pc == $past(st_pc) + AW'(1)));

  p_no_pf_during_ctl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ir_valid && op_code[SW-1]) |-> !(mem_req && mem_kind == 2'd0));

  p_slot_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_slot != IW'(NS - 1) && !(op_code[SW-1] && op_code[SW-2] && xfer_take))
    |=> (op_slot == $past(op_slot) + IW'(1)));

  p_port_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ir_valid && st_pf_full && !op_code[SW-1]) |-> !mem_req);
endmodule

bind slot_sequencer slot_seq_chk #(.SW(SW), .NS(NS), .AW(AW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_slot    (op_slot),
  .mem_req    (mem_req),
  .mem_kind   (mem_kind),
  .mem_ack    (mem_ack),
  .xfer_take  (xfer_take),
  .st_ir_valid(st_ir_valid),
  .st_pf_full (st_pf_full),
  .st_pc      (st_pc),
  .ev_pf_done (ev_pf_done)
);

// File: tb/slot_sequencer_tb_top.sv
`timescale 1ns/1ps
module slot_sequencer_tb_top;
  localparam int SW = 5, NS = 4, AW = 16, WW = 20;
  localparam logic [4:0] OP_LIT = 5'b10000, OP_DAT = 5'b10001, OP_JMP = 5'b11000;

  // Table: straight-line program words (bit 4 clear in every slot).
  localparam logic [WW-1:0] VEC_PROG [6] = '{
    {5'd1,  5'd2,  5'd3,  5'd4},
    {5'd5,  5'd6,  5'd7,  5'd8},
    {5'd15, 5'd0,  5'd9,  5'd14},
    {5'd10, 5'd11, 5'd12, 5'd13},
    {5'd3,  5'd3,  5'd1,  5'd2},
    {5'd8,  5'd4,  5'd15, 5'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_req, mem_ack, op_valid, xfer_take;
  logic [1:0] mem_kind, op_slot;
  logic [AW-1:0] mem_addr, data_addr, xfer_target;
  logic [WW-1:0] mem_rdata;
  logic [SW-1:0] op_code;

  always #4 clk = ~clk;

  slot_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_kind(mem_kind), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .data_addr(data_addr), .xfer_take(xfer_take),
    .xfer_target(xfer_target), .op_valid(op_valid), .op_code(op_code), .op_slot(op_slot)
  );

  // Memory model: acknowledges once a request has been held wait_cyc cycles.
  logic [WW-1:0] mem_arr [64];
  int wait_cyc = 0;
  logic [AW+1:0] key, key_q;
  logic req_q;
  int cnt_q, held;

  always_comb begin
    key       = {mem_kind, mem_addr};
    held      = (req_q && key == key_q) ? cnt_q + 1 : 0;
    mem_ack   = mem_req && (held >= wait_cyc);
    mem_rdata = (mem_kind == 2'd2) ? 20'hDA7A0 : mem_arr[mem_addr[5:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0; key_q <= '0; cnt_q <= 0;
    end else begin
      req_q <= mem_req && !mem_ack; key_q <= key; cnt_q <= held;
    end
  end

  // Monitor: logs issues, completed accesses and request level per cycle.
  int cyc, n_ops, n_acc;
  int op_cyc [64]; logic [4:0] op_c [64]; logic [1:0] op_s [64];
  int acc_cyc [64]; logic [1:0] acc_k [64]; logic [AW-1:0] acc_a [64]; logic [WW-1:0] acc_d [64];
  logic req_l [256];

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; n_ops = 0; n_acc = 0;
    end else begin
      if (cyc < 256) req_l[cyc] = mem_req;
      if (op_valid && n_ops < 64) begin
        op_cyc[n_ops] = cyc; op_c[n_ops] = op_code; op_s[n_ops] = op_slot; n_ops++;
      end
      if (mem_req && mem_ack && n_acc < 64) begin
        acc_cyc[n_acc] = cyc; acc_k[n_acc] = mem_kind; acc_a[n_acc] = mem_addr;
        acc_d[n_acc] = mem_rdata; n_acc++;
      end
      cyc++;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 64; i++) mem_arr[i] = '0;
  endtask

  task automatic start(input int w, input logic take, input logic [AW-1:0] tgt, input logic [AW-1:0] da);
    rst_n = 1'b0; wait_cyc = w; xfer_take = take; xfer_target = tgt; data_addr = da;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(!op_valid && mem_req && mem_kind == 2'd0 && mem_addr == '0, "R1", "state after reset",
        {op_valid, mem_req, mem_kind, 16'(mem_addr)}, {1'b0, 1'b1, 2'd0, 16'd0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    xfer_take = 1'b0; xfer_target = '0; data_addr = '0;
    clr_mem();

    // Table walk: straight-line words, short memory wait.
    for (int i = 0; i < 6; i++) mem_arr[i] = VEC_PROG[i];
    start(1, 1'b0, '0, '0);
    repeat (40) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      logic [WW-1:0] got;
      bit slots_ok;
      got = {op_c[4*i], op_c[4*i+1], op_c[4*i+2], op_c[4*i+3]};
      slots_ok = 1'b1;
      for (int k = 0; k < 4; k++) if (op_s[4*i+k] != 2'(k)) slots_ok = 1'b0;
      chk(got == VEC_PROG[i] && slots_ok, "R2", "word slot order", int'(got), int'(VEC_PROG[i]));
      chk(acc_k[i] == 2'd0 && acc_a[i] == AW'(i), "R6", "fetch address", int'(acc_a[i]), i);
    end
    chk(op_cyc[3] - op_cyc[0] == 3, "R3", "single-cycle slots", op_cyc[3] - op_cyc[0], 3);
    chk(op_cyc[23] - op_cyc[0] == 23, "R4", "no gap between words", op_cyc[23] - op_cyc[0], 23);

    // R5: long wait, each word's slot 0 follows its read acknowledge.
    start(6, 1'b0, '0, '0);
    repeat (80) @(posedge clk);
    for (int w = 0; w < 4; w++)
      chk(op_cyc[4*w] == acc_cyc[w] + 1 && op_s[4*w] == 2'd0, "R5", "slot 0 after read",
          op_cyc[4*w], acc_cyc[w] + 1);

    // R7 / R10: data opcode in slot 1 drops the prefetch.
    clr_mem();
    mem_arr[0] = {5'd1, OP_DAT, 5'd2, 5'd3};
    mem_arr[1] = {5'd4, 5'd5, 5'd6, 5'd7};
    start(2, 1'b0, '0, 16'h002A);
    repeat (30) @(posedge clk);
    chk(acc_k[1] == 2'd2 && acc_a[1] == 16'h002A, "R7", "data access request", int'(acc_a[1]), 'h2A);
    chk(op_c[1] == OP_DAT && op_cyc[1] == acc_cyc[1], "R7", "data op issues on ack", op_cyc[1], acc_cyc[1]);
    chk(acc_k[2] == 2'd0 && acc_a[2] == 16'd1, "R10", "prefetch restart address", int'(acc_a[2]), 1);
    chk(op_c[4] == 5'd4, "R10", "next word executes", int'(op_c[4]), 4);

    // R8 / R11: literal with the next word already buffered, zero wait.
    clr_mem();
    mem_arr[0] = {5'd1, 5'd2, OP_LIT, 5'd3};
    mem_arr[1] = 20'h12345;
    mem_arr[2] = {5'd4, 5'd5, 5'd6, 5'd7};
    start(0, 1'b0, '0, '0);
    repeat (30) @(posedge clk);
    chk(req_l[op_cyc[1]] == 1'b0, "R11", "port idle with full buffer", int'(req_l[op_cyc[1]]), 0);
    chk(acc_k[2] == 2'd1 && acc_a[2] == 16'd1, "R8", "literal address", int'(acc_a[2]), 1);
    chk(acc_d[2] == 20'h12345, "R8", "literal data", int'(acc_d[2]), 'h12345);
    chk(op_c[2] == OP_LIT && op_cyc[2] == acc_cyc[2], "R8", "literal issues on ack", op_cyc[2], acc_cyc[2]);
    chk(acc_k[3] == 2'd0 && acc_a[3] == 16'd2, "R8", "fetch after literal", int'(acc_a[3]), 2);
    chk(op_c[3] == 5'd3 && op_c[4] == 5'd4, "R8", "literal word skipped", int'(op_c[4]), 4);

    // R9: taken transfer.
    clr_mem();
    mem_arr[0]     = {5'd1, OP_JMP, 5'd5, 5'd6};
    mem_arr[1]     = {5'd11, 5'd12, 5'd13, 5'd14};
    mem_arr[16]    = {5'd7, 5'd8, 5'd9, 5'd10};
    start(1, 1'b1, 16'h0010, '0);
    repeat (30) @(posedge clk);
    chk(op_c[1] == OP_JMP, "R9", "transfer issues", int'(op_c[1]), int'(OP_JMP));
    chk(op_c[2] == 5'd7 && op_s[2] == 2'd0, "R9", "rest of word dropped", int'(op_c[2]), 7);
    chk(acc_k[1] == 2'd0 && acc_a[1] == 16'h0010, "R9", "fetch at target", int'(acc_a[1]), 'h10);

    // R9: transfer not taken continues in order.
    start(1, 1'b0, 16'h0010, '0);
    repeat (30) @(posedge clk);
    chk(op_c[2] == 5'd5 && op_s[2] == 2'd2, "R9", "not taken continues", int'(op_c[2]), 5);
    chk(op_c[4] == 5'd11, "R9", "next sequential word", int'(op_c[4]), 11);
    chk(acc_a[1] == 16'd1, "R10", "prefetch after transfer", int'(acc_a[1]), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule